// File: doc/BRIEF.md
# Byte-Lane Transfer Buffer for a Two-Wire Serial Controller

This block holds the small shared data word that sits between a register-bus data port and a two-wire serial byte engine. Software writes transmit data as 16-bit halfwords or as one trailing byte. The engine pulls transmit bytes out oldest first. In the other direction, the engine drops received bytes into successive byte lanes, and software drains them as 16-bit halfwords. A byte-order input selects which of the two bytes in each halfword travels first.

The buffer keeps separate transmit and receive byte counts over one shared word. Around each access it produces single-cycle status effect strobes, which the controller's status logic applies: a rejected write, transmit-underflow clear, transmit-ready clear, single-byte-data set, receive-ready clear, access-ready set, master clear and receive-overrun clear. Deciding when bus transactions happen is the job of the surrounding controller.

Byte lane k is word bits [8k+7:8k] (with LANE_W = 8). At most one operation is serviced per clock.

Top module: `i2cbuf_top`

## Requirements
- R1: An accepted 16-bit write (tx_count ≤ 2) shifts the word left 16 bits and adds 2 to tx_count. With big_endian=1, wr_data[15:8] lands in lane 1 and wr_data[7:0] in lane 0. With big_endian=0, the two bytes go to the opposite lanes.
- R2: An accepted 8-bit write shifts the word left 8 bits, places wr_data[7:0] in lane 0 and adds 1 to tx_count.
- R3: A write of either width while tx_count > 2 is refused. It pulses wr_reject, leaves the word and both counts unchanged, and raises no status clear.
- R4: Every accepted write pulses clr_xudf. It also pulses clr_xrdy when the resulting tx_count exceeds 2.
- R5: tx_byte shows lane (tx_count−1), or zero when tx_count is 0. A pop decrements tx_count, so bytes leave in the order they were written. A pop at tx_count 0 is ignored.
- R6: A received byte is ORed into lane rx_count and rx_count increments. A push while rx_count is 4 is ignored.
- R7: rd_data presents lanes 0 and 1. It is {lane0, lane1} when big_endian=1 and {lane1, lane0} when big_endian=0.
- R8: A read with rx_count 1 pulses set_sbd and sets rx_count to 0. A read with rx_count > 2 shifts the word right 16 bits. Any read with rx_count > 1 subtracts 2. A read at rx_count 0 changes no count.
- R9: A read after which rx_count is 0 pulses clr_rrdy. If master_rx is high, that read also pulses set_ardy and clr_mst.
- R10: Every read pulses clr_rovr.
- R11: start_clr zeroes the word and leaves both counts unchanged.
- R12: When several strobes are high in the same cycle, only the highest-priority one is serviced. The order is start_clr, wr16_en, wr8_en, rd16_en, tx_pop, rx_push.
- R13: After reset, the word and both counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| big_endian | input | 1 | Byte-order select for halfword access |
| master_rx | input | 1 | Controller is currently a master receiver |
| start_clr | input | 1 | Start issued: clear the word |
| wr16_en | input | 1 | 16-bit data write strobe |
| wr8_en | input | 1 | 8-bit data write strobe |
| wr_data | input | 16 | Write data |
| rd16_en | input | 1 | 16-bit data read strobe |
| rd_data | output | 16 | Read data (valid while rd16_en is serviced) |
| tx_pop | input | 1 | Engine takes the next transmit byte |
| tx_byte | output | 8 | Next transmit byte |
| tx_count | output | 3 | Queued transmit bytes |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| rx_count | output | 3 | Held received bytes |
| wr_reject | output | 1 | Write refused |
| clr_xudf | output | 1 | Clear transmit-underflow status |
| clr_xrdy | output | 1 | Clear transmit-ready status |
| set_sbd | output | 1 | Set single-byte-data status |
| clr_rrdy | output | 1 | Clear receive-ready status |
| set_ardy | output | 1 | Set access-ready status |
| clr_mst | output | 1 | Clear the master bit |
| clr_rovr | output | 1 | Clear receive-overrun status |

## Verification
The bench builds the block with its defaults, LANE_W = 8 and LANES = 4. With those values every count from 0 to 4 is reachable within a few operations. For both byte orders and several data patterns, the bench sweeps every receive fill level from one to four bytes, plus an over-full push. It also covers the mixed halfword-plus-byte transmit fill, the refused write and the same-cycle priority cases, with expected bytes derived arithmetically from the written values.

// File: rtl/i2cbuf_pkg.sv
package i2cbuf_pkg;
   typedef enum logic [2:0] {
      OP_IDLE, OP_CLEAR, OP_WR16, OP_WR8, OP_RD16, OP_POP, OP_PUSH
   } buf_op_e;
endpackage

// File: rtl/i2cbuf_op_arb.sv
module i2cbuf_op_arb
   import i2cbuf_pkg::*;
(
   input  logic    start_clr,
   input  logic    wr16_en,
   input  logic    wr8_en,
   input  logic    rd16_en,
   input  logic    tx_pop,
   input  logic    rx_push,
   output buf_op_e op
);
   // Fixed priority: one operation per cycle (R12)
   always_comb begin
      if (start_clr)    op = OP_CLEAR;
      else if (wr16_en) op = OP_WR16;
      else if (wr8_en)  op = OP_WR8;
      else if (rd16_en) op = OP_RD16;
      else if (tx_pop)  op = OP_POP;
      else if (rx_push) op = OP_PUSH;
      else              op = OP_IDLE;
   end
endmodule

// File: rtl/i2cbuf_wr_pack.sv
module i2cbuf_wr_pack #(
   parameter int LANE_W = 8,
   parameter int LANES  = 4,
   localparam int WORD_W = LANE_W * LANES,
   localparam int ACC_W  = 2 * LANE_W
) (
   input  logic [WORD_W-1:0] word,
   input  logic [ACC_W-1:0]  data,
   input  logic              big_endian,
   input  logic              is_byte,
   output logic [WORD_W-1:0] new_word
);
   logic [ACC_W-1:0] ordered;

   // big-endian keeps the high byte in lane 1 (R1)
   assign ordered = big_endian ? data
                               : {data[LANE_W-1:0], data[ACC_W-1:LANE_W]};

   always_comb begin
      if (is_byte)
         new_word = (word << LANE_W) | WORD_W'(data[LANE_W-1:0]);
      else
         new_word = (word << ACC_W) | WORD_W'(ordered);
   end
endmodule

// File: rtl/i2cbuf_rd_unpack.sv
module i2cbuf_rd_unpack #(
   parameter int LANE_W = 8,
   parameter int LANES  = 4,
   localparam int WORD_W = LANE_W * LANES,
   localparam int ACC_W  = 2 * LANE_W,
   localparam int CNT_W  = $clog2(LANES + 1)
) (
   input  logic [WORD_W-1:0] word,
   input  logic [CNT_W-1:0]  rx_cnt,
   input  logic              big_endian,
   output logic [ACC_W-1:0]  rd_data,
   output logic [WORD_W-1:0] nxt_word,
   output logic [CNT_W-1:0]  nxt_rx,
   output logic              single_byte
);
   logic [LANE_W-1:0] l0, l1;
   assign l0 = word[LANE_W-1:0];
   assign l1 = word[ACC_W-1:LANE_W];
   assign rd_data = big_endian ? {l0, l1} : {l1, l0};

   always_comb begin
      nxt_word    = word;
      nxt_rx      = rx_cnt;
      single_byte = 1'b0;
      if (rx_cnt == CNT_W'(1)) begin
         single_byte = 1'b1;
         nxt_rx      = '0;
      end else if (rx_cnt > CNT_W'(1)) begin
         if (rx_cnt > CNT_W'(2)) nxt_word = word >> ACC_W;
         nxt_rx = rx_cnt - CNT_W'(2);
      end
   end
endmodule

// File: rtl/i2cbuf_top.sv
module i2cbuf_top
   import i2cbuf_pkg::*;
#(
   parameter int LANE_W = 8,
   parameter int LANES  = 4,
   localparam int WORD_W = LANE_W * LANES,
   localparam int ACC_W  = 2 * LANE_W,
   localparam int CNT_W  = $clog2(LANES + 1),
   localparam int IDX_W  = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              big_endian,
   input  logic              master_rx,
   input  logic              start_clr,
   input  logic              wr16_en,
   input  logic              wr8_en,
   input  logic [ACC_W-1:0]  wr_data,
   input  logic              rd16_en,
   output logic [ACC_W-1:0]  rd_data,
   input  logic              tx_pop,
   output logic [LANE_W-1:0] tx_byte,
   output logic [CNT_W-1:0]  tx_count,
   input  logic              rx_push,
   input  logic [LANE_W-1:0] rx_byte,
   output logic [CNT_W-1:0]  rx_count,
   output logic              wr_reject,
   output logic              clr_xudf,
   output logic              clr_xrdy,
   output logic              set_sbd,
   output logic              clr_rrdy,
   output logic              set_ardy,
   output logic              clr_mst,
   output logic              clr_rovr
);
   generate
      if (LANES < 2 || (LANES % 2) != 0)
         $error("LANES must be an even number of at least 2");
      if (LANE_W < 1)
         $error("LANE_W must be positive");
   endgenerate

   localparam logic [CNT_W-1:0] WR_LIMIT = CNT_W'(LANES - 2);
   localparam logic [CNT_W-1:0] FULL     = CNT_W'(LANES);

   buf_op_e           op;
   logic [WORD_W-1:0] word_q, pack_word, rd_word, push_word;
   logic [CNT_W-1:0]  tx_q, rx_q, rd_rx, tx_after;
   logic              rd_single, is_wr, wr_ok, rd_empty;
   logic [LANE_W-1:0] lane [LANES];

   i2cbuf_op_arb u_arb (
      .start_clr(start_clr), .wr16_en(wr16_en), .wr8_en(wr8_en),
      .rd16_en(rd16_en), .tx_pop(tx_pop), .rx_push(rx_push), .op(op)
   );

   i2cbuf_wr_pack #(.LANE_W(LANE_W), .LANES(LANES)) u_pack (
      .word(word_q), .data(wr_data), .big_endian(big_endian),
      .is_byte(op == OP_WR8), .new_word(pack_word)
   );

   i2cbuf_rd_unpack #(.LANE_W(LANE_W), .LANES(LANES)) u_unpack (
      .word(word_q), .rx_cnt(rx_q), .big_endian(big_endian),
      .rd_data(rd_data), .nxt_word(rd_word), .nxt_rx(rd_rx),
      .single_byte(rd_single)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane[g] = word_q[g*LANE_W +: LANE_W];
   end

   assign tx_byte   = (tx_q == '0) ? '0 : lane[IDX_W'(tx_q - CNT_W'(1))];
   assign push_word = word_q | (WORD_W'(rx_byte) << (LANE_W * int'(rx_q)));

   // status effects
   assign is_wr     = (op == OP_WR16) || (op == OP_WR8);
   assign wr_ok     = (tx_q <= WR_LIMIT);
   assign tx_after  = tx_q + ((op == OP_WR16) ? CNT_W'(2) : CNT_W'(1));
   assign wr_reject = is_wr && !wr_ok;
   assign clr_xudf  = is_wr && wr_ok;
   assign clr_xrdy  = clr_xudf && (tx_after > WR_LIMIT);
   assign set_sbd   = (op == OP_RD16) && rd_single;
   assign rd_empty  = (op == OP_RD16) && (rd_rx == '0);
   assign clr_rrdy  = rd_empty;
   assign set_ardy  = rd_empty && master_rx;
   assign clr_mst   = rd_empty && master_rx;
   assign clr_rovr  = (op == OP_RD16);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         tx_q   <= '0;
         rx_q   <= '0;
      end else begin
         case (op)
            OP_CLEAR: word_q <= '0;
            OP_WR16, OP_WR8: if (wr_ok) begin
               word_q <= pack_word;
               tx_q   <= tx_after;
            end
            OP_RD16: begin
               word_q <= rd_word;
               rx_q   <= rd_rx;
            end
            OP_POP:  if (tx_q != '0) tx_q <= tx_q - CNT_W'(1);
            OP_PUSH: if (rx_q < FULL) begin
               word_q <= push_word;
               rx_q   <= rx_q + CNT_W'(1);
            end
            default: ;
         endcase
      end
   end

   assign tx_count = tx_q;
   assign rx_count = rx_q;

   assert_wr16_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_WR16 && tx_q <= WR_LIMIT) |=> tx_q == $past(tx_q) + CNT_W'(2));
   assert_wr8_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_WR8 && tx_q <= WR_LIMIT) |=> tx_q == $past(tx_q) + CNT_W'(1));
   assert_reject_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_reject) |=> ($stable(tx_q) && $stable(word_q)));
   assert_pop_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_POP && tx_q != '0) |=> tx_q == $past(tx_q) - CNT_W'(1));
   assert_push_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_PUSH && rx_q == FULL) |=> ($stable(rx_q) && $stable(word_q)));
   assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_q <= FULL) && (tx_q <= FULL));
   assert_sbd_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (set_sbd) |=> rx_q == '0);
   assert_clear_keeps_counts_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_CLEAR) |=> ($stable(tx_q) && $stable(rx_q) && word_q == '0));
endmodule

// File: tb/i2cbuf_top_bench.sv
module i2cbuf_top_bench;
   logic clk = 1'b0, rst_n = 1'b0;
   logic big_endian = 0, master_rx = 0, start_clr = 0, wr16_en = 0, wr8_en = 0;
   logic rd16_en = 0, tx_pop = 0, rx_push = 0;
   logic [15:0] wr_data = '0, rd_data;
   logic [7:0]  rx_byte = '0, tx_byte;
   logic [2:0]  tx_count, rx_count;
   logic wr_reject, clr_xudf, clr_xrdy, set_sbd, clr_rrdy, set_ardy, clr_mst, clr_rovr;

   int checks = 0, errors = 0;
   bit done = 0;
   // strobe captures taken before the servicing edge
   logic [15:0] c_rd;
   logic c_rej, c_xudf, c_xrdy, c_sbd, c_rrdy, c_ardy, c_mst, c_rovr;

   always #10 clk = ~clk;   // 50 MHz

   i2cbuf_top u_i2cbuf_top (.*);

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic op(input logic s, w16, w8, rd, pp, ps,
                     input logic [15:0] d, input logic [7:0] rb);
      @(negedge clk);
      start_clr = s; wr16_en = w16; wr8_en = w8; rd16_en = rd;
      tx_pop = pp; rx_push = ps; wr_data = d; rx_byte = rb;
      #2;
      c_rd = rd_data; c_rej = wr_reject; c_xudf = clr_xudf; c_xrdy = clr_xrdy;
      c_sbd = set_sbd; c_rrdy = clr_rrdy; c_ardy = set_ardy; c_mst = clr_mst;
      c_rovr = clr_rovr;
      @(posedge clk); #1;
      start_clr = 0; wr16_en = 0; wr8_en = 0; rd16_en = 0; tx_pop = 0; rx_push = 0;
   endtask

   task automatic clr();               op(1,0,0,0,0,0,16'h0,8'h0); endtask
   task automatic w16(logic [15:0] v); op(0,1,0,0,0,0,v,8'h0);     endtask
   task automatic w8(logic [7:0] v);   op(0,0,1,0,0,0,{8'h0,v},8'h0); endtask
   task automatic rd();                op(0,0,0,1,0,0,16'h0,8'h0); endtask
   task automatic pop();               op(0,0,0,0,1,0,16'h0,8'h0); endtask
   task automatic push(logic [7:0] b); op(0,0,0,0,0,1,16'h0,b);    endtask

   task automatic drain_tx();
      while (tx_count != 0) pop();
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #35 rst_n = 1'b1;
      #2;
      check("R13 tx_count", tx_count, 0);
      check("R13 rx_count", rx_count, 0);
      check("R13 tx_byte", tx_byte, 0);
      check("R13 rd_data", rd_data, 0);

      for (int be = 0; be < 2; be++) begin
         for (int p = 0; p < 4; p++) begin
            logic [15:0] v1, v2;
            logic [7:0]  c, f1, s1, f2, s2;
            logic [7:0]  b [4];
            big_endian = be[0];
            master_rx  = p[0];
            v1 = {8'(p*37+5), 8'(p*91+17)};
            v2 = {8'(p*53+9), 8'(p*29+200)};
            c  = 8'(p*13+101);
            f1 = be ? v1[15:8] : v1[7:0];  s1 = be ? v1[7:0] : v1[15:8];
            f2 = be ? v2[15:8] : v2[7:0];  s2 = be ? v2[7:0] : v2[15:8];

            // halfword then trailing byte
            drain_tx(); clr();
            w16(v1);
            check("R1 tx_count", tx_count, 2);
            check("R4 clr_xudf", c_xudf, 1);
            check("R4 clr_xrdy at 2", c_xrdy, 0);
            w8(c);
            check("R2 tx_count", tx_count, 3);
            check("R4 clr_xrdy at 3", c_xrdy, 1);
            w16(v2);
            check("R3 reject pulse", c_rej, 1);
            check("R3 no xudf clear", c_xudf, 0);
            check("R3 tx_count held", tx_count, 3);
            check("R5 first byte", tx_byte, f1);  pop();
            check("R5 second byte", tx_byte, s1); pop();
            check("R2 trailing byte", tx_byte, c); pop();
            check("R5 empty", tx_count, 0);
            pop();
            check("R5 pop at zero", tx_count, 0);
            check("R5 tx_byte zero", tx_byte, 0);

            // two halfwords
            clr(); w16(v1); w16(v2);
            check("R4 clr_xrdy at 4", c_xrdy, 1);
            check("R1 full", tx_count, 4);
            w8(c);
            check("R3 byte reject", c_rej, 1);
            check("R1 b0", tx_byte, f1); pop();
            check("R1 b1", tx_byte, s1); pop();
            check("R1 b2", tx_byte, f2); pop();
            check("R1 b3", tx_byte, s2); pop();

            // R11: clear keeps counts
            w16(v1); clr();
            check("R11 tx_count kept", tx_count, 2);
            check("R11 word zero", tx_byte, 0);
            // R12: write wins over pop
            op(0,0,1,0,1,0,{8'h0,c},8'h0);
            check("R12 write wins", tx_count, 3);
            check("R12 new byte", u_i2cbuf_top.tx_count, 3);
            drain_tx();

            // receive fills 1..4
            for (int n = 1; n <= 4; n++) begin
               clr();
               for (int k = 0; k < 4; k++) b[k] = (k < n) ? 8'(p*16 + n*4 + k + 1) : 8'h0;
               for (int k = 0; k < n; k++) push(b[k]);
               check("R6 rx_count", rx_count, n);
               if (n == 4) begin
                  push(8'hFF);
                  check("R6 push when full", rx_count, 4);
               end
               rd();
               check("R7 first read", c_rd, be ? {b[0], b[1]} : {b[1], b[0]});
               check("R10 clr_rovr", c_rovr, 1);
               check("R8 sbd first", c_sbd, n == 1);
               check("R8 rx after first", rx_count, n == 1 ? 0 : n - 2);
               check("R9 clr_rrdy", c_rrdy, n <= 2);
               check("R9 set_ardy", c_ardy, (n <= 2) && p[0]);
               check("R9 clr_mst", c_mst, (n <= 2) && p[0]);
               if (n >= 3) begin
                  rd();
                  check("R8 shifted read", c_rd, be ? {b[2], b[3]} : {b[3], b[2]});
                  check("R8 sbd second", c_sbd, n == 3);
                  check("R8 rx drained", rx_count, 0);
                  check("R9 clr_rrdy second", c_rrdy, 1);
               end
               rd();
               check("R8 empty read count", rx_count, 0);
               check("R8 empty no sbd", c_sbd, 0);
               check("R10 empty clr_rovr", c_rovr, 1);
               check("R9 empty clr_rrdy", c_rrdy, 1);
            end
         end
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule